// File: doc/BRIEF.md
# Bus Request Address Fault Checker

This block sits between a small 32-bit processor and its bus. Each cycle it looks at the request the processor issues and decides whether it may proceed. The decision uses the kind of access (instruction fetch, data read, data write, stack access or vector-table access), its size (byte, word or longword), the region the address falls in, the single-chip strap and the low bits of the vector base register. A request that breaks a rule is held back from the bus. In the same cycle an error strobe and a cause code go out. The request address and the cause are recorded so that exception logic can read them later.

Three address regions are parameters: the on-chip peripheral window, a narrow 8-bit-wide part of that window, and the external memory window. Only one cause is reported per request. A fixed priority applies: fetch rules first, then region rules, then alignment rules. The recorded fault stays put until the clear input is pulsed. This way a burst of follow-on faults cannot overwrite the first one.

Top module: `bus_addr_guard`

## Requirements
- R1: A fetch (kind code 0) at an odd address reports cause 1, whatever the other inputs are.
- R2: A fetch at an even address inside the peripheral window reports cause 2.
- R3: If the single-chip strap is high, any access of any kind into the external window reports cause 3, unless R1 or R2 applies first. If the strap is low, the external window never raises an error.
- R4: A longword (size code 2) access of a non-fetch kind into the 8-bit peripheral part reports cause 4, even when the address is a multiple of four.
- R5: A stack access (kind code 3) whose address has a nonzero value in bits 1:0 reports cause 5, whatever its size.
- R6: A vector-table access (kind code 4) made while bits 1:0 of the vector base value are nonzero reports cause 6.
- R7: A longword data read (kind 1) or data write (kind 2) whose address has a nonzero value in bits 1:0 reports cause 7.
- R8: A word (size code 1) data read or write at an odd address reports cause 8. A byte (size code 0) access never raises cause 5, 7 or 8 in any kind, except as R5 requires for stack accesses.
- R9: When several rules match, the reported cause is the first one in this order: 1, 2, 3, 4, 5, 6, 7, 8. A legal request reports cause 0.
- R10: The error strobe is high exactly when the request is valid and the cause is nonzero. The forwarded bus request is high exactly when the request is valid and no error fires. Both act in the same cycle as the request.
- R11: After reset the recorded address and cause are zero. On a clock edge where the strobe is high and nothing is recorded, the address and cause are captured. They then hold until the clear input is high at an edge. A clear at an edge where the strobe is high captures the new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Processor request present |
| req_addr_i | input | 32 | Request address |
| req_kind_i | input | 3 | 0 fetch, 1 data read, 2 data write, 3 stack, 4 vector |
| req_size_i | input | 2 | 0 byte, 1 word, 2 longword |
| single_chip_i | input | 1 | Single-chip strap; external window is forbidden when high |
| vbr_i | input | 32 | Current vector base register value |
| fault_clr_i | input | 1 | Releases the recorded fault |
| bus_req_o | output | 1 | Request forwarded to the bus |
| err_o | output | 1 | Address error strobe |
| err_cause_o | output | 4 | Cause of the current request |
| fault_addr_o | output | 32 | Recorded faulting address |
| fault_cause_o | output | 4 | Recorded cause, 0 when nothing is held |

## Verification
A wrong region decode or a wrong priority shows up at the ports in the same cycle as the request. The cause code is wrong, and either the strobe or the forwarded request is wrong with it. A recording register that fails to hold, or that captures when it should not, shows up one edge later as a changed fault address or cause. The reference model in the bench predicts both views each cycle. Directed cases cover each rule, stacked rules and clear timing, and a long random run covers the rest.

// File: rtl/bus_addr_guard_pkg.sv
package bus_addr_guard_pkg;

    typedef enum logic [2:0] {
        K_FETCH  = 3'd0,
        K_DREAD  = 3'd1,
        K_DWRITE = 3'd2,
        K_STACK  = 3'd3,
        K_VECTOR = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [3:0] {
        C_NONE         = 4'd0,
        C_FETCH_ODD    = 4'd1,
        C_FETCH_PERIPH = 4'd2,
        C_EXT_SINGLE   = 4'd3,
        C_PERIPH_LONG  = 4'd4,
        C_STACK_MIS    = 4'd5,
        C_VBR_MIS      = 4'd6,
        C_LONG_MIS     = 4'd7,
        C_WORD_ODD     = 4'd8
    } fault_cause_e;

    typedef struct packed {
        logic periph;
        logic periph8;
        logic ext;
    } region_hit_t;

    localparam int unsigned NUM_REGIONS = 3;

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/bag_region_decode.sv
module bag_region_decode
    import bus_addr_guard_pkg::*;
#(
    parameter logic [31:0] PERIPH_LO  = 32'hFFFF_8000,
    parameter logic [31:0] PERIPH_HI  = 32'hFFFF_FFFF,
    parameter logic [31:0] PERIPH8_LO = 32'hFFFF_8000,
    parameter logic [31:0] PERIPH8_HI = 32'hFFFF_83FF,
    parameter logic [31:0] EXT_LO     = 32'h0040_0000,
    parameter logic [31:0] EXT_HI     = 32'h03FF_FFFF
) (
    input  logic [31:0] addr_i,
    output region_hit_t hit_o
);
    localparam logic [31:0] LO_TAB [NUM_REGIONS] = '{PERIPH_LO, PERIPH8_LO, EXT_LO};
    localparam logic [31:0] HI_TAB [NUM_REGIONS] = '{PERIPH_HI, PERIPH8_HI, EXT_HI};

    logic [NUM_REGIONS-1:0] hits;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        assign hits[g] = in_window(addr_i, LO_TAB[g], HI_TAB[g]);
    end

    assign hit_o.periph  = hits[0];
    assign hit_o.periph8 = hits[1];
    assign hit_o.ext     = hits[2];
endmodule

// File: rtl/bag_rule_eval.sv
module bag_rule_eval
    import bus_addr_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [31:0]  addr_i,
    input  acc_kind_e    kind_i,
    input  acc_size_e    size_i,
    input  logic         single_chip_i,
    input  logic [31:0]  vbr_i,
    input  region_hit_t  hit_i,
    output fault_cause_e cause_o
);
    logic is_fetch, is_data, vbr_bad, lo2_bad;

    assign is_fetch = (kind_i == K_FETCH);
    assign is_data  = (kind_i == K_DREAD) || (kind_i == K_DWRITE);
    assign vbr_bad  = (vbr_i & 32'h3) != 32'h0;
    assign lo2_bad  = addr_i[1:0] != 2'b00;

    always_comb begin
        cause_o = C_NONE;
        if (!valid_i)                                          cause_o = C_NONE;
        else if (is_fetch && addr_i[0])                        cause_o = C_FETCH_ODD;
        else if (is_fetch && hit_i.periph)                     cause_o = C_FETCH_PERIPH;
        else if (single_chip_i && hit_i.ext)                   cause_o = C_EXT_SINGLE;
        else if (!is_fetch && size_i == SZ_LONG && hit_i.periph8) cause_o = C_PERIPH_LONG;
        else if (kind_i == K_STACK && lo2_bad)                 cause_o = C_STACK_MIS;
        else if (kind_i == K_VECTOR && vbr_bad)                cause_o = C_VBR_MIS;
        else if (is_data && size_i == SZ_LONG && lo2_bad)      cause_o = C_LONG_MIS;
        else if (is_data && size_i == SZ_WORD && addr_i[0])    cause_o = C_WORD_ODD;
    end

    assert_fetch_odd_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == K_FETCH && addr_i[0]) |-> cause_o == C_FETCH_ODD);

    assert_ext_free_R3: assert property (@(posedge clk) disable iff (rst)
        (!single_chip_i) |-> cause_o != C_EXT_SINGLE);

    assert_byte_no_align_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && size_i == SZ_BYTE) |-> (cause_o != C_LONG_MIS && cause_o != C_WORD_ODD));

    assert_periph_long_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i != K_FETCH && size_i == SZ_LONG && hit_i.periph8
         && !(single_chip_i && hit_i.ext)) |-> cause_o == C_PERIPH_LONG);
endmodule

// File: rtl/bag_fault_latch.sv
module bag_fault_latch
    import bus_addr_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         err_i,
    input  fault_cause_e cause_i,
    input  logic [31:0]  addr_i,
    input  logic         clr_i,
    output fault_cause_e cause_q,
    output logic [31:0]  addr_q
);
    logic held;
    assign held = (cause_q != C_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= C_NONE;
            addr_q  <= '0;
        end else if (clr_i) begin
            cause_q <= err_i ? cause_i : C_NONE;
            addr_q  <= err_i ? addr_i  : '0;
        end else if (err_i && !held) begin
            cause_q <= cause_i;
            addr_q  <= addr_i;
        end
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (held && !clr_i) |=> ($stable(cause_q) && $stable(addr_q)));

    assert_capture_R11: assert property (@(posedge clk) disable iff (rst)
        (err_i && (!held || clr_i)) |=> (cause_q == $past(cause_i) && addr_q == $past(addr_i)));
endmodule

// File: rtl/bus_addr_guard.sv
module bus_addr_guard
    import bus_addr_guard_pkg::*;
#(
    parameter logic [31:0] PERIPH_LO  = 32'hFFFF_8000,
    parameter logic [31:0] PERIPH_HI  = 32'hFFFF_FFFF,
    parameter logic [31:0] PERIPH8_LO = 32'hFFFF_8000,
    parameter logic [31:0] PERIPH8_HI = 32'hFFFF_83FF,
    parameter logic [31:0] EXT_LO     = 32'h0040_0000,
    parameter logic [31:0] EXT_HI     = 32'h03FF_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid_i,
    input  logic [31:0] req_addr_i,
    input  logic [2:0]  req_kind_i,
    input  logic [1:0]  req_size_i,
    input  logic        single_chip_i,
    input  logic [31:0] vbr_i,
    input  logic        fault_clr_i,
    output logic        bus_req_o,
    output logic        err_o,
    output logic [3:0]  err_cause_o,
    output logic [31:0] fault_addr_o,
    output logic [3:0]  fault_cause_o
);
    region_hit_t  hit;
    fault_cause_e cause, held_cause;

    bag_region_decode #(
        .PERIPH_LO(PERIPH_LO), .PERIPH_HI(PERIPH_HI),
        .PERIPH8_LO(PERIPH8_LO), .PERIPH8_HI(PERIPH8_HI),
        .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) u_dec (
        .addr_i (req_addr_i),
        .hit_o  (hit)
    );

    bag_rule_eval u_rules (
        .clk           (clk),
        .rst           (rst),
        .valid_i       (req_valid_i),
        .addr_i        (req_addr_i),
        .kind_i        (acc_kind_e'(req_kind_i)),
        .size_i        (acc_size_e'(req_size_i)),
        .single_chip_i (single_chip_i),
        .vbr_i         (vbr_i),
        .hit_i         (hit),
        .cause_o       (cause)
    );

    assign err_o       = req_valid_i && (cause != C_NONE);
    assign bus_req_o   = req_valid_i && !err_o;
    assign err_cause_o = cause;

    bag_fault_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .err_i   (err_o),
        .cause_i (cause),
        .addr_i  (req_addr_i),
        .clr_i   (fault_clr_i),
        .cause_q (held_cause),
        .addr_q  (fault_addr_o)
    );

    assign fault_cause_o = held_cause;

    assert_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !bus_req_o);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |-> (!err_o && !bus_req_o));
endmodule

// File: tb/bus_addr_guard_tb_top.sv
`timescale 1ns/1ps
module bus_addr_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid_i;
    logic [31:0] req_addr_i;
    logic [2:0]  req_kind_i;
    logic [1:0]  req_size_i;
    logic        single_chip_i;
    logic [31:0] vbr_i;
    logic        fault_clr_i;
    logic        bus_req_o, err_o;
    logic [3:0]  err_cause_o, fault_cause_o;
    logic [31:0] fault_addr_o;

    int checks = 0;
    int fails  = 0;

    logic [3:0]  m_cause = 4'd0;
    logic [31:0] m_addr  = 32'd0;

    always #2.5 clk = ~clk;

    bus_addr_guard dut_i (.*);

    function automatic logic [3:0] ref_cause(input logic v, input logic [2:0] k,
        input logic [1:0] s, input logic [31:0] a, input logic sc, input logic [31:0] vb);
        bit fetch  = (k == 3'd0);
        bit data   = (k == 3'd1) || (k == 3'd2);
        bit per    = a >= 32'hFFFF_8000;
        bit per8   = a >= 32'hFFFF_8000 && a <= 32'hFFFF_83FF;
        bit ext    = a >= 32'h0040_0000 && a <= 32'h03FF_FFFF;
        logic [3:0] found [$];
        if (!v) return 4'd0;
        if (fetch && a[0])                     found.push_back(4'd1);
        if (fetch && per)                      found.push_back(4'd2);
        if (sc && ext)                         found.push_back(4'd3);
        if (!fetch && s == 2'd2 && per8)       found.push_back(4'd4);
        if (k == 3'd3 && a[1:0] != 0)          found.push_back(4'd5);
        if (k == 3'd4 && vb[1:0] != 0)         found.push_back(4'd6);
        if (data && s == 2'd2 && a[1:0] != 0)  found.push_back(4'd7);
        if (data && s == 2'd1 && a[0])         found.push_back(4'd8);
        if (found.size() == 0) return 4'd0;
        return found[0];
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] k, input logic [1:0] s,
                        input logic [31:0] a, input logic sc, input logic [31:0] vb,
                        input logic clr, input string tag);
        logic [3:0] ec;
        @(negedge clk);
        req_valid_i = v; req_kind_i = k; req_size_i = s; req_addr_i = a;
        single_chip_i = sc; vbr_i = vb; fault_clr_i = clr;
        #1;
        ec = ref_cause(v, k, s, a, sc, vb);
        chk({28'd0, err_cause_o}, {28'd0, ec}, {tag, " cause"});
        chk({31'd0, err_o}, {31'd0, v && ec != 0}, "R10 strobe");
        chk({31'd0, bus_req_o}, {31'd0, v && ec == 0}, "R10 forward");
        @(posedge clk);
        if (clr) begin
            m_cause = (v && ec != 0) ? ec : 4'd0;
            m_addr  = (v && ec != 0) ? a : 32'd0;
        end else if (v && ec != 0 && m_cause == 0) begin
            m_cause = ec; m_addr = a;
        end
        #1;
        chk({28'd0, fault_cause_o}, {28'd0, m_cause}, "R11 held cause");
        chk(fault_addr_o, m_addr, "R11 held addr");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid_i = 0; req_addr_i = 0; req_kind_i = 0; req_size_i = 0;
        single_chip_i = 0; vbr_i = 0; fault_clr_i = 0;
        repeat (3) @(posedge clk);
        #1;
        chk({28'd0, fault_cause_o}, 32'd0, "R11 reset cause");
        chk(fault_addr_o, 32'd0, "R11 reset addr");
        @(negedge clk); rst = 1'b0;

        step(1, 3'd1, 2'd2, 32'h0000_1000, 0, 0, 0, "R10 legal");
        step(1, 3'd0, 2'd1, 32'h0000_2001, 0, 0, 1, "R1 fetch odd");
        step(1, 3'd0, 2'd1, 32'hFFFF_9000, 0, 0, 1, "R2 fetch periph");
        step(1, 3'd0, 2'd1, 32'hFFFF_9001, 1, 3, 1, "R9 odd over periph");
        step(1, 3'd1, 2'd0, 32'h0050_0000, 1, 0, 1, "R3 ext single");
        step(1, 3'd2, 2'd2, 32'h0050_0002, 0, 0, 1, "R3 ext normal R7");
        step(1, 3'd0, 2'd1, 32'h0050_0000, 1, 0, 1, "R3 fetch ext");
        step(1, 3'd1, 2'd2, 32'hFFFF_8004, 0, 0, 1, "R4 long periph8");
        step(1, 3'd1, 2'd2, 32'hFFFF_8006, 0, 0, 1, "R9 periph8 over align");
        step(1, 3'd1, 2'd2, 32'hFFFF_9004, 0, 0, 1, "R4 outside periph8");
        step(1, 3'd3, 2'd0, 32'h0000_3001, 0, 0, 1, "R5 stack byte");
        step(1, 3'd3, 2'd2, 32'h0000_3004, 0, 0, 1, "R5 stack ok");
        step(1, 3'd4, 2'd2, 32'h0000_0010, 0, 2, 1, "R6 vbr bad");
        step(1, 3'd4, 2'd2, 32'h0000_0010, 0, 4, 1, "R6 vbr ok");
        step(1, 3'd2, 2'd2, 32'h0000_4002, 0, 0, 1, "R7 long mis");
        step(1, 3'd1, 2'd1, 32'h0000_4003, 0, 0, 1, "R8 word odd");
        step(1, 3'd1, 2'd0, 32'h0000_4003, 0, 0, 1, "R8 byte odd");
        step(0, 3'd0, 2'd1, 32'h0000_2001, 0, 0, 1, "R10 idle");
        step(1, 3'd0, 2'd1, 32'h0000_5001, 0, 0, 1, "R11 first");
        step(1, 3'd1, 2'd1, 32'h0000_6003, 0, 0, 0, "R11 second held");
        step(1, 3'd1, 2'd1, 32'h0000_6000, 0, 0, 0, "R11 legal held");
        step(0, 3'd0, 2'd0, 32'h0, 0, 0, 1, "R11 clear");
        step(1, 3'd1, 2'd1, 32'h0000_7001, 0, 0, 0, "R11 recapture");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [2:0] k;
            int r;
            r = $urandom_range(0, 3);
            a = $urandom;
            if (r == 0) a = 32'hFFFF_8000 | ($urandom & 32'h7FF);
            if (r == 1) a = 32'h0040_0000 + ($urandom & 32'hFF);
            if (r == 2) a = a & 32'h0000_FFFF;
            k = 3'($urandom_range(0, 4));
            step($urandom_range(0, 7) != 0, k, 2'($urandom_range(0, 2)), a,
                 1'($urandom), $urandom, $urandom_range(0, 5) == 0, "R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule